// File: doc/BRIEF.md
# Keyed Configuration Port

This block is the configuration front end of a multi-function I/O controller. A host reaches it over a simple byte-wide I/O bus through two addresses: an index port at 0x2E and a data port at 0x2F. The port stays closed until a four-byte key has been written to the index port. Once it is open, the host writes a register number to the index port. It then reads or writes that register through the data port. A dedicated exit command closes the port again.

The register space holds a few global registers and a banked window. The global registers are a logical device select, a 16-bit chip identifier split over two bytes, and a revision nibble. The banked window is a per-logical-device register file, and the device select picks which bank the window shows. The bank of the GPIO device (device 7) carries a 16-bit base address, which is also driven out of the block so that the I/O decoder for the GPIO data ports can use it. The identifier value 0xFFFF is reserved to mean "no device" and must not be used as the `CHIP_ID` parameter.

Read data is registered. A read strobe on either port updates `ioRdData` at the clock edge that samples the strobe. Between reads, `ioRdData` holds its value.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked (`cfgUnlocked` low), `ioRdData` is 0xFF, `gpioBase` is 0x0000, the register index is 0x00 and the logical device select is 0x00.
- R2: The port unlocks only when the bytes 0x87, 0x01, 0x55 and 0x55 are written to the index port (0x2E) in that order; `cfgUnlocked` rises in the cycle after the fourth write.
- R3: While locked, a byte at the index port that does not match the expected key byte sends the matcher back to its start. If that byte is 0x87, it counts as the first key byte.
- R4: While locked, writes to the data port change no register, and reads of either port return 0xFF.
- R5: While unlocked, an index-port write sets the register index. An index-port read returns the index. A data-port read returns the indexed register one cycle after the read strobe.
- R6: Register 0x20 reads the high byte of the chip ID and register 0x21 reads the low byte. Register 0x22 reads the revision in bits 3:0, with bits 7:4 zero.
- R7: Register 0x07 is the read/write logical device select. Registers 0x60 to 0x6F form a window onto a separate bank for each device number below `NUM_LDN`.
- R8: `gpioBase` is the bank of device 7: register 0x62 gives bits 15:8 and register 0x63 gives bits 7:0. Writes to these offsets while another device is selected leave `gpioBase` unchanged.
- R9: Writing 0x02 to register 0x02 locks the port and returns the index to 0x00. Any other value written there has no effect. Register contents survive the lock.
- R10: Writes to registers 0x20 to 0x22 are ignored. Reads of registers that do not exist return 0xFF. With a device number at or above `NUM_LDN` selected, the window reads 0xFF and ignores writes. Register 0x02 reads 0x00.
- R11: A read and a write in the same cycle on the same port return the state from before the write: the register value, the lock state, or the device select as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrEn | input | 1 | Host write strobe, one cycle per byte |
| ioRdEn | input | 1 | Host read strobe, one cycle per byte |
| ioAddr | input | ADDR_W | Host I/O address |
| ioWrData | input | 8 | Host write byte |
| ioRdData | output | 8 | Registered read byte |
| cfgUnlocked | output | 1 | High while configuration access is open |
| gpioBase | output | 16 | Base address held in the GPIO device bank |

## Verification
On this bus a read and a write can share a cycle. In that cycle the write can be the one that changes what the read sees: the final key byte, the exit command, or a new device select. The bench drives both strobes together in each of these three cases. It checks that the returned byte reflects the state before the edge. It then checks that the following access sees the new state: the port unlocked, the port locked, or the new select.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  // Register numbers whose positions are decoded by the host side
  localparam logic [7:0] EXIT_REG  = 8'h02;
  localparam logic [7:0] EXIT_CMD  = 8'h02;
  localparam logic [7:0] LDN_REG   = 8'h07;
  localparam logic [7:0] ID_HI_REG = 8'h20;
  localparam logic [7:0] ID_LO_REG = 8'h21;
  localparam logic [7:0] REV_REG   = 8'h22;
  localparam logic [7:0] GPIO_HI_REG = 8'h62;
  localparam logic [7:0] GPIO_LO_REG = 8'h63;

  // Control-to-datapath strobes
  typedef struct packed {
    logic       locked;   // port closed this cycle
    logic       portRd;   // read on index or data port
    logic       rdIdx;    // that read targets the index port
    logic       regWr;    // accepted data-port write
    logic [7:0] regIdx;   // current register index
    logic [7:0] wrByte;   // host write byte
  } cfgStrobes_t;

  // Key byte expected at each matcher step
  function automatic logic [7:0] keyByte(input logic [1:0] step);
    case (step)
      2'd0:    keyByte = 8'h87;
      2'd1:    keyByte = 8'h01;
      default: keyByte = 8'h55;
    endcase
  endfunction

endpackage

// File: rtl/cfg_key_ctrl.sv
module cfg_key_ctrl
  import cfg_port_pkg::*;
#(
  parameter int                 ADDR_W     = 16,
  parameter logic [ADDR_W-1:0]  INDEX_ADDR = 16'h002E,
  parameter logic [ADDR_W-1:0]  DATA_ADDR  = 16'h002F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  output cfgStrobes_t       strobes,
  output logic              unlocked
);

  localparam logic [1:0] LAST_STEP = 2'd3;

  logic       unlockedQ;
  logic [1:0] keyStep;
  logic [7:0] idxQ;
  logic       idxHit;
  logic       dataHit;
  logic       idxWr;
  logic       keyMatch;
  logic       exitHit;

  assign idxHit   = (ioAddr == INDEX_ADDR);
  assign dataHit  = (ioAddr == DATA_ADDR);
  assign idxWr    = ioWrEn && idxHit;
  assign keyMatch = (ioWrData == keyByte(keyStep));

  always_comb begin
    strobes.locked = !unlockedQ;
    strobes.portRd = ioRdEn && (idxHit || dataHit);
    strobes.rdIdx  = idxHit;
    strobes.regWr  = ioWrEn && dataHit && unlockedQ;
    strobes.regIdx = idxQ;
    strobes.wrByte = ioWrData;
  end

  assign exitHit  = strobes.regWr && (idxQ == EXIT_REG) && (ioWrData == EXIT_CMD);
  assign unlocked = unlockedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlockedQ <= 1'b0;
      keyStep   <= 2'd0;
      idxQ      <= 8'h00;
    end else if (!unlockedQ) begin
      if (idxWr) begin
        if (keyMatch) begin
          if (keyStep == LAST_STEP) begin
            unlockedQ <= 1'b1;
            keyStep   <= 2'd0;
          end else begin
            keyStep <= keyStep + 2'd1;
          end
        end else if (ioWrData == keyByte(2'd0)) begin
          keyStep <= 2'd1;
        end else begin
          keyStep <= 2'd0;
        end
      end
    end else begin
      if (exitHit) begin
        unlockedQ <= 1'b0;
        idxQ      <= 8'h00;
      end else if (idxWr) begin
        idxQ <= ioWrData;
      end
    end
  end

  // R2: opening happens only on the last key byte at the index port
  assert_unlock_on_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlockedQ) |-> $past(idxWr && keyStep == LAST_STEP && ioWrData == 8'h55));

  // R3: a stray 0x87 while locked restarts the matcher at step one
  assert_restart_on_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!unlockedQ && idxWr && ioWrData == 8'h87 && keyStep != 2'd0) |=> (keyStep == 2'd1));

  // R9: the exit command always closes the port
  assert_exit_relocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (unlockedQ && ioWrEn && dataHit && idxQ == EXIT_REG && ioWrData == EXIT_CMD)
      |=> (!unlockedQ && idxQ == 8'h00));

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
#(
  parameter int          NUM_LDN    = 8,
  parameter int          BANK_DEPTH = 16,
  parameter logic [7:0]  BANK_LO    = 8'h60,
  parameter int          GPIO_LDN   = 7,
  parameter logic [15:0] CHIP_ID    = 16'h5A31,
  parameter logic [3:0]  REVISION   = 4'h6
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobes_t strobes,
  output logic [7:0]  ioRdData,
  output logic [15:0] gpioBase
);

  localparam int         LDN_W     = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;
  localparam int         BANK_W    = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
  localparam logic [8:0] BANK_END  = 9'(BANK_LO) + 9'(BANK_DEPTH);
  localparam logic [8:0] NUM_LDN_B = 9'(NUM_LDN);
  localparam logic [7:0] GPIO_LDN_B  = 8'(GPIO_LDN);
  localparam logic [BANK_W-1:0] GPIO_HI_OFF = BANK_W'(GPIO_HI_REG - BANK_LO);
  localparam logic [BANK_W-1:0] GPIO_LO_OFF = BANK_W'(GPIO_LO_REG - BANK_LO);

  logic [7:0]        ldnSel;
  logic [7:0]        bankMem [NUM_LDN][BANK_DEPTH];
  logic [LDN_W-1:0]  ldnIdx;
  logic [BANK_W-1:0] bankOff;
  logic              inBank;
  logic              ldnOk;
  logic              bankWr;
  logic [7:0]        readVal;
  logic              gpioWr;

  assign ldnIdx  = ldnSel[LDN_W-1:0];
  assign ldnOk   = ({1'b0, ldnSel} < NUM_LDN_B);
  assign inBank  = (strobes.regIdx >= BANK_LO) && ({1'b0, strobes.regIdx} < BANK_END);
  assign bankOff = BANK_W'(strobes.regIdx - BANK_LO);
  assign bankWr  = strobes.regWr && inBank && ldnOk;

  // Device select
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldnSel <= 8'h00;
    end else if (strobes.regWr && strobes.regIdx == LDN_REG) begin
      ldnSel <= strobes.wrByte;
    end
  end

  // Banked register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int d = 0; d < NUM_LDN; d++) begin
        for (int r = 0; r < BANK_DEPTH; r++) begin
          bankMem[d][r] <= 8'h00;
        end
      end
    end else if (bankWr) begin
      bankMem[ldnIdx][bankOff] <= strobes.wrByte;
    end
  end

  // Register read mux
  always_comb begin
    readVal = 8'hFF;
    if (strobes.regIdx == EXIT_REG) begin
      readVal = 8'h00;
    end else if (strobes.regIdx == LDN_REG) begin
      readVal = ldnSel;
    end else if (strobes.regIdx == ID_HI_REG) begin
      readVal = CHIP_ID[15:8];
    end else if (strobes.regIdx == ID_LO_REG) begin
      readVal = CHIP_ID[7:0];
    end else if (strobes.regIdx == REV_REG) begin
      readVal = {4'h0, REVISION};
    end else if (inBank && ldnOk) begin
      readVal = bankMem[ldnIdx][bankOff];
    end
  end

  // Registered host read data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioRdData <= 8'hFF;
    end else if (strobes.portRd) begin
      if (strobes.locked) begin
        ioRdData <= 8'hFF;
      end else if (strobes.rdIdx) begin
        ioRdData <= strobes.regIdx;
      end else begin
        ioRdData <= readVal;
      end
    end
  end

  generate
    if (GPIO_LDN < NUM_LDN) begin : g_gpioBase
      assign gpioBase = {bankMem[GPIO_LDN][GPIO_HI_OFF], bankMem[GPIO_LDN][GPIO_LO_OFF]};
    end else begin : g_noGpio
      assign gpioBase = 16'h0000;
    end
  endgenerate

  assign gpioWr = strobes.regWr && (ldnSel == GPIO_LDN_B) &&
                  (strobes.regIdx == GPIO_HI_REG || strobes.regIdx == GPIO_LO_REG);

  // R4: a read while locked always yields 0xFF
  assert_locked_reads_ff_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.portRd && strobes.locked) |=> (ioRdData == 8'hFF));

  // R7: the device select moves only on a write to its register
  assert_ldn_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.regWr && strobes.regIdx == LDN_REG) |=> $stable(ldnSel));

  // R8: the GPIO base moves only on a write to its bytes in the GPIO bank
  assert_gpio_base_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !gpioWr |=> $stable(gpioBase));

  // R5: without a read strobe the read byte is held
  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.portRd |=> $stable(ioRdData));

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h002E,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h002F,
  parameter int                NUM_LDN    = 8,
  parameter int                BANK_DEPTH = 16,
  parameter logic [7:0]        BANK_LO    = 8'h60,
  parameter int                GPIO_LDN   = 7,
  parameter logic [15:0]       CHIP_ID    = 16'h5A31,
  parameter logic [3:0]        REVISION   = 4'h6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  output logic              cfgUnlocked,
  output logic [15:0]       gpioBase
);

  cfgStrobes_t strobes;

  cfg_key_ctrl #(
    .ADDR_W     (ADDR_W),
    .INDEX_ADDR (INDEX_ADDR),
    .DATA_ADDR  (DATA_ADDR)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ioWrEn   (ioWrEn),
    .ioRdEn   (ioRdEn),
    .ioAddr   (ioAddr),
    .ioWrData (ioWrData),
    .strobes  (strobes),
    .unlocked (cfgUnlocked)
  );

  cfg_reg_bank #(
    .NUM_LDN    (NUM_LDN),
    .BANK_DEPTH (BANK_DEPTH),
    .BANK_LO    (BANK_LO),
    .GPIO_LDN   (GPIO_LDN),
    .CHIP_ID    (CHIP_ID),
    .REVISION   (REVISION)
  ) u_bank (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .ioRdData (ioRdData),
    .gpioBase (gpioBase)
  );

endmodule

// File: tb/keyed_cfg_port_test.sv
`timescale 1ns/1ps
module keyed_cfg_port_test;

  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;
  localparam logic [15:0] ID_VAL  = 16'h5A31;
  localparam logic [3:0]  REV_VAL = 4'h6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioWrEn = 1'b0;
  logic        ioRdEn = 1'b0;
  logic [15:0] ioAddr = 16'h0000;
  logic [7:0]  ioWrData = 8'h00;
  logic [7:0]  ioRdData;
  logic        cfgUnlocked;
  logic [15:0] gpioBase;

  int totalCount = 0;
  int failCount  = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keyed_cfg_port #(
    .ADDR_W(16), .INDEX_ADDR(IDX), .DATA_ADDR(DAT), .NUM_LDN(8),
    .BANK_DEPTH(16), .BANK_LO(8'h60), .GPIO_LDN(7),
    .CHIP_ID(ID_VAL), .REVISION(REV_VAL)
  ) uut (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioAddr(ioAddr), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .cfgUnlocked(cfgUnlocked), .gpioBase(gpioBase)
  );

  task automatic check(string req, string what, logic [15:0] actual, logic [15:0] expected);
    totalCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, actual, expected);
    end
  endtask

  task automatic ioWrite(logic [15:0] addr, logic [7:0] data);
    @(negedge clk);
    ioAddr = addr; ioWrData = data; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic ioRead(logic [15:0] addr, output logic [7:0] data);
    @(negedge clk);
    ioAddr = addr; ioRdEn = 1'b1;
    @(negedge clk);
    ioRdEn = 1'b0;
    data = ioRdData;
  endtask

  task automatic ioWriteRead(logic [15:0] addr, logic [7:0] wdata, output logic [7:0] rdata);
    @(negedge clk);
    ioAddr = addr; ioWrData = wdata; ioWrEn = 1'b1; ioRdEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0; ioRdEn = 1'b0;
    rdata = ioRdData;
  endtask

  task automatic sendKey();
    ioWrite(IDX, 8'h87); ioWrite(IDX, 8'h01);
    ioWrite(IDX, 8'h55); ioWrite(IDX, 8'h55);
  endtask

  task automatic regWrite(logic [7:0] idx, logic [7:0] val);
    ioWrite(IDX, idx); ioWrite(DAT, val);
  endtask

  task automatic regRead(logic [7:0] idx, output logic [7:0] val);
    ioWrite(IDX, idx); ioRead(DAT, val);
  endtask

  task automatic exitCfg();
    regWrite(8'h02, 8'h02);
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R1", "locked after reset", 16'(cfgUnlocked), 16'h0);
    check("R1", "read byte after reset", 16'(ioRdData), 16'hFF);
    check("R1", "gpio base after reset", gpioBase, 16'h0000);
    sendKey();
    ioRead(IDX, v);
    check("R1", "index after reset", 16'(v), 16'h00);
    regRead(8'h07, v);
    check("R1", "device select after reset", 16'(v), 16'h00);
    exitCfg();
  endtask

  task automatic testUnlock();
    logic [7:0] v;
    ioWrite(IDX, 8'h87); ioWrite(IDX, 8'h01); ioWrite(IDX, 8'h55);
    check("R2", "locked after three key bytes", 16'(cfgUnlocked), 16'h0);
    ioRead(DAT, v);
    check("R2", "data read before full key", 16'(v), 16'hFF);
    ioWrite(IDX, 8'h55);
    check("R2", "unlocked after fourth key byte", 16'(cfgUnlocked), 16'h1);
    ioWrite(IDX, 8'h21);
    ioRead(IDX, v);
    check("R5", "index port readback", 16'(v), 16'h21);
    ioRead(DAT, v);
    check("R5", "data read of indexed register", 16'(v), 16'(ID_VAL[7:0]));
    exitCfg();
  endtask

  task automatic testBadKey();
    ioWrite(IDX, 8'h87); ioWrite(IDX, 8'h01); ioWrite(IDX, 8'h55); ioWrite(IDX, 8'h54);
    check("R3", "wrong last byte keeps lock", 16'(cfgUnlocked), 16'h0);
    ioWrite(IDX, 8'h87); ioWrite(IDX, 8'h01); ioWrite(IDX, 8'h87);
    ioWrite(IDX, 8'h01); ioWrite(IDX, 8'h55); ioWrite(IDX, 8'h55);
    check("R3", "0x87 restarts at step one", 16'(cfgUnlocked), 16'h1);
    exitCfg();
    ioWrite(IDX, 8'h87); ioWrite(IDX, 8'h87); ioWrite(IDX, 8'h01);
    ioWrite(IDX, 8'h55); ioWrite(IDX, 8'h55);
    check("R3", "repeated 0x87 then key", 16'(cfgUnlocked), 16'h1);
    exitCfg();
    ioWrite(IDX, 8'h87); ioWrite(IDX, 8'h01); ioWrite(IDX, 8'h55); ioWrite(IDX, 8'h87);
    ioWrite(IDX, 8'h01); ioWrite(IDX, 8'h55); ioWrite(IDX, 8'h55);
    check("R3", "0x87 in last step restarts", 16'(cfgUnlocked), 16'h1);
    exitCfg();
    ioWrite(IDX, 8'h87); ioWrite(IDX, 8'h01); ioWrite(IDX, 8'h00);
    ioWrite(IDX, 8'h55); ioWrite(IDX, 8'h55);
    check("R3", "wrong byte resets to start", 16'(cfgUnlocked), 16'h0);
  endtask

  task automatic testLockedIgnore();
    logic [7:0] v;
    sendKey();
    regWrite(8'h07, 8'h03);
    exitCfg();
    ioWrite(DAT, 8'h05);
    ioRead(DAT, v);
    check("R4", "locked data read", 16'(v), 16'hFF);
    ioRead(IDX, v);
    check("R4", "locked index read", 16'(v), 16'hFF);
    sendKey();
    regRead(8'h07, v);
    check("R4", "locked data write ignored", 16'(v), 16'h03);
    regWrite(8'h07, 8'h00);
    exitCfg();
  endtask

  task automatic testIdRev();
    logic [7:0] v;
    sendKey();
    regRead(8'h20, v);
    check("R6", "chip id high", 16'(v), 16'(ID_VAL[15:8]));
    regRead(8'h21, v);
    check("R6", "chip id low", 16'(v), 16'(ID_VAL[7:0]));
    regRead(8'h22, v);
    check("R6", "revision", 16'(v), 16'({4'h0, REV_VAL}));
    regWrite(8'h20, 8'h00);
    regWrite(8'h22, 8'hF0);
    regRead(8'h20, v);
    check("R10", "id write ignored", 16'(v), 16'(ID_VAL[15:8]));
    regRead(8'h22, v);
    check("R10", "revision write ignored", 16'(v), 16'({4'h0, REV_VAL}));
    regRead(8'h40, v);
    check("R10", "missing register reads FF", 16'(v), 16'hFF);
    regRead(8'h02, v);
    check("R10", "exit register reads 00", 16'(v), 16'h00);
    exitCfg();
  endtask

  task automatic testBanks();
    logic [7:0] v;
    sendKey();
    regWrite(8'h07, 8'h01);
    regWrite(8'h60, 8'h11);
    regWrite(8'h6F, 8'h1F);
    regWrite(8'h07, 8'h02);
    regWrite(8'h60, 8'h22);
    regRead(8'h07, v);
    check("R7", "device select readback", 16'(v), 16'h02);
    regRead(8'h60, v);
    check("R7", "bank 2 first byte", 16'(v), 16'h22);
    regRead(8'h6F, v);
    check("R7", "bank 2 last byte untouched", 16'(v), 16'h00);
    regWrite(8'h07, 8'h0A);
    regWrite(8'h60, 8'h99);
    regRead(8'h60, v);
    check("R10", "out of range device reads FF", 16'(v), 16'hFF);
    regWrite(8'h07, 8'h01);
    regRead(8'h60, v);
    check("R7", "bank 1 first byte", 16'(v), 16'h11);
    regRead(8'h6F, v);
    check("R7", "bank 1 last byte", 16'(v), 16'h1F);
    regWrite(8'h07, 8'h02);
    regRead(8'h60, v);
    check("R10", "out of range write did not alias", 16'(v), 16'h22);
    exitCfg();
  endtask

  task automatic testGpioBase();
    sendKey();
    regWrite(8'h07, 8'h07);
    regWrite(8'h62, 8'h0A);
    check("R8", "gpio base high byte", gpioBase, 16'h0A00);
    regWrite(8'h63, 8'h40);
    check("R8", "gpio base low byte", gpioBase, 16'h0A40);
    regWrite(8'h07, 8'h03);
    regWrite(8'h62, 8'hFF);
    check("R8", "other device leaves base", gpioBase, 16'h0A40);
    exitCfg();
    check("R8", "base kept after lock", gpioBase, 16'h0A40);
  endtask

  task automatic testExit();
    logic [7:0] v;
    sendKey();
    regWrite(8'h07, 8'h05);
    regWrite(8'h02, 8'h01);
    check("R9", "other value keeps port open", 16'(cfgUnlocked), 16'h1);
    ioWrite(IDX, 8'h02);
    ioWrite(DAT, 8'h02);
    check("R9", "exit command locks", 16'(cfgUnlocked), 16'h0);
    ioRead(DAT, v);
    check("R9", "read after exit", 16'(v), 16'hFF);
    sendKey();
    ioRead(IDX, v);
    check("R9", "index cleared by exit", 16'(v), 16'h00);
    regRead(8'h07, v);
    check("R9", "select kept across lock", 16'(v), 16'h05);
    regWrite(8'h07, 8'h00);
    exitCfg();
  endtask

  task automatic testSameCycle();
    logic [7:0] v;
    sendKey();
    regWrite(8'h07, 8'h04);
    ioWrite(IDX, 8'h07);
    ioWriteRead(DAT, 8'h06, v);
    check("R11", "select read during write is old", 16'(v), 16'h04);
    ioRead(DAT, v);
    check("R11", "select after write is new", 16'(v), 16'h06);
    ioWrite(IDX, 8'h02);
    ioWriteRead(DAT, 8'h02, v);
    check("R11", "read during exit", 16'(v), 16'h00);
    check("R11", "locked after exit cycle", 16'(cfgUnlocked), 16'h0);
    ioWrite(IDX, 8'h87); ioWrite(IDX, 8'h01); ioWrite(IDX, 8'h55);
    ioWriteRead(IDX, 8'h55, v);
    check("R11", "read during final key byte", 16'(v), 16'hFF);
    check("R11", "unlocked after key cycle", 16'(cfgUnlocked), 16'h1);
    regWrite(8'h07, 8'h00);
    exitCfg();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnlock();
    testBadKey();
    testLockedIgnore();
    testIdRev();
    testBanks();
    testGpioBase();
    testExit();
    testSameCycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", totalCount - failCount, totalCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      totalCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", totalCount - failCount, totalCount);
      $finish;
    end
  end

endmodule